// File: doc/BRIEF.md
# Component-Split Capture FIFO Bank

This block buffers the incoming video samples of one capture channel in three lanes: lane 0 for luma, lane 1 for blue-difference chroma and lane 2 for red-difference chroma. Each lane gathers 8-bit samples into 64-bit words and stores them in a 16-word FIFO. A memory-mapped read strobe takes one word off the FIFO. A lane raises a one-cycle DMA request event each time its fill level reaches a programmable threshold.

A two-bit mode input selects which lanes are active. In component mode all three lanes take data. In raw and transport-stream modes only the luma lane takes data. In those modes the two chroma lanes stay idle: their read ports return zero and they raise no events. A capture port with two channels uses two instances of this block.

Top module: `capture_fifo_bank`

## Requirements
- R1: After reset, every read-data lane is zero and all event, underrun and overrun bits are low.
- R2: A read strobe on a non-empty active lane removes that lane's oldest word. The word appears on the lane's read-data field in the next cycle and stays there until the next read or flush.
- R3: Each lane packs 8-bit samples little-endian. The first sample of a word goes to bits [7:0] and the eighth to bits [63:56]. The word enters the FIFO at the clock edge that takes the eighth sample.
- R4: Each lane holds up to 16 words.
- R5: A lane's event goes high for exactly one cycle when its fill level goes from below the threshold to at or above it. It fires again only after the level has dropped below the threshold. A threshold of 0 acts as 1.
- R6: A read strobe on an empty active lane returns zero, moves no pointer and sets that lane's sticky underrun bit.
- R7: A word completed while a lane holds 16 words is dropped and sets that lane's sticky overrun bit. A read at the same edge does not make room.
- R8: Mode encoding: 00 is component capture with all three lanes active. 01 is raw capture, 10 is transport-stream capture and 11 is also raw. In the three non-component modes lanes 1 and 2 ignore samples and read strobes, return zero read data, stay empty and raise no event or flag.
- R9: At a clock edge where mode_i differs from the mode captured at the previous edge, every lane is emptied. The edge also discards partly packed words, clears events and read data, and ignores samples and reads. Sticky flags are kept.
- R10: In raw and transport-stream modes, lane 0 packs the samples from the lane-0 sample input in the same way as in component mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Capture mode (R8 encoding) |
| thresh_i | input | 5 | Event threshold in words, 0 to 16 |
| smp_vld_i | input | 3 | Sample strobe, one bit per lane |
| smp_dat_i | input | 24 | Samples; lane k at bits [8k+7:8k] |
| rd_i | input | 3 | Read-pop strobe, one bit per lane |
| rd_data_o | output | 192 | Read words; lane k at bits [64k+63:64k] |
| evt_o | output | 3 | DMA request event pulse per lane |
| underrun_o | output | 3 | Sticky empty-read flag per lane |
| overrun_o | output | 3 | Sticky full-drop flag per lane |

## Verification
The bench runs a full-FIFO edge where a read and a completed word coincide. A design that let the pop make room would store a word that should be dropped and miss the overrun bit. The bench switches modes in the middle of a word and checks that the next word begins at bits [7:0]. Stale partial samples would show up as shifted bytes. It drives chroma traffic in the single-lane modes, where a leaky gate would produce words, events or flags on idle lanes. It also sweeps thresholds including 0 and 16, so a design that re-armed on every write, or never fired at the boundary, would differ from the reference in the event stream.

// File: rtl/capfifo_pkg.sv
package capfifo_pkg;
   typedef enum logic [1:0] {
      CAP_COMPONENT = 2'b00,
      CAP_RAW       = 2'b01,
      CAP_STREAM    = 2'b10,
      CAP_RAW_ALT   = 2'b11
   } cap_mode_e;

   // Lane 0 (luma) is always fed; chroma lanes only in component capture.
   function automatic logic lane_active(input logic [1:0] mode, input int lane);
      return (lane == 0) || (mode == CAP_COMPONENT);
   endfunction
endpackage

// File: rtl/capfifo_packer.sv
module capfifo_packer #(
   parameter int SMP_W  = 8,
   parameter int WORD_W = 64
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic              flush_i,
   input  logic              vld_i,
   input  logic [SMP_W-1:0]  dat_i,
   output logic              wr_o,
   output logic [WORD_W-1:0] word_o
);
   localparam int SPW = WORD_W / SMP_W;
   localparam int CW  = $clog2(SPW);

   logic [CW-1:0]           cnt_q;
   logic [WORD_W-SMP_W-1:0] part_q;
   logic                    last;

   assign last   = (cnt_q == CW'(SPW - 1));
   assign wr_o   = vld_i && !flush_i && last;
   assign word_o = {dat_i, part_q};

   always_ff @(posedge clk_i) begin
      if (!rst_n_i || flush_i) begin
         cnt_q  <= '0;
         part_q <= '0;
      end else if (vld_i) begin
         if (!last) part_q[cnt_q*SMP_W +: SMP_W] <= dat_i;
         cnt_q <= last ? '0 : cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/capfifo_lane.sv
module capfifo_lane #(
   parameter int WORD_W = 64,
   parameter int DEPTH  = 16,
   parameter int LVL_W  = $clog2(DEPTH) + 1
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic              flush_i,
   input  logic              wr_i,
   input  logic [WORD_W-1:0] wr_word_i,
   input  logic              rd_i,
   input  logic [LVL_W-1:0]  thr_i,
   output logic [WORD_W-1:0] rd_data_o,
   output logic              evt_o,
   output logic              und_o,
   output logic              ovr_o,
   output logic [LVL_W-1:0]  lvl_o
);
   localparam int AW = $clog2(DEPTH);

   logic [WORD_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wptr_q, rptr_q;
   logic [LVL_W-1:0]  lvl_q, lvl_nxt, thr_eff;
   logic              full, empty, wr_ok, rd_ok, armed_q;

   assign full    = (lvl_q == LVL_W'(DEPTH));
   assign empty   = (lvl_q == '0);
   assign wr_ok   = wr_i && !full && !flush_i;
   assign rd_ok   = rd_i && !empty && !flush_i;
   assign lvl_nxt = lvl_q + LVL_W'(wr_ok) - LVL_W'(rd_ok);
   assign thr_eff = (thr_i == '0) ? LVL_W'(1) : thr_i;
   assign lvl_o   = lvl_q;

   always_ff @(posedge clk_i) begin
      if (wr_ok) mem[wptr_q] <= wr_word_i;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_n_i) begin
         wptr_q <= '0; rptr_q <= '0; lvl_q <= '0;
         rd_data_o <= '0; evt_o <= 1'b0; armed_q <= 1'b1;
         und_o <= 1'b0; ovr_o <= 1'b0;
      end else if (flush_i) begin
         wptr_q <= '0; rptr_q <= '0; lvl_q <= '0;
         rd_data_o <= '0; evt_o <= 1'b0; armed_q <= 1'b1;
      end else begin
         lvl_q <= lvl_nxt;
         if (wr_ok) wptr_q <= wptr_q + 1'b1;
         if (wr_i && full) ovr_o <= 1'b1;
         if (rd_i) begin
            if (empty) begin
               rd_data_o <= '0;
               und_o     <= 1'b1;
            end else begin
               rd_data_o <= mem[rptr_q];
               rptr_q    <= rptr_q + 1'b1;
            end
         end
         if (armed_q && lvl_nxt >= thr_eff) begin
            evt_o   <= 1'b1;
            armed_q <= 1'b0;
         end else begin
            evt_o <= 1'b0;
            if (lvl_nxt < thr_eff) armed_q <= 1'b1;
         end
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      lvl_q <= LVL_W'(DEPTH)); // R4
   AST_EVT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      evt_o |=> !evt_o); // R5
   AST_UNDERRUN_ZERO: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (rd_i && empty && !flush_i) |=> (und_o && rd_data_o == '0 && rptr_q == $past(rptr_q))); // R6
   AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (wr_i && full && !rd_i && !flush_i) |=> (full && ovr_o)); // R7
   AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      flush_i |=> (empty && !evt_o && rd_data_o == '0)); // R9
endmodule

// File: rtl/capture_fifo_bank.sv
module capture_fifo_bank
   import capfifo_pkg::*;
#(
   parameter int SMP_W  = 8,
   parameter int WORD_W = 64,
   parameter int DEPTH  = 16,
   parameter int LANES  = 3,
   localparam int LVL_W = $clog2(DEPTH) + 1
) (
   input  logic                    clk_i,
   input  logic                    rst_n_i,
   input  logic [1:0]              mode_i,
   input  logic [LVL_W-1:0]        thresh_i,
   input  logic [LANES-1:0]        smp_vld_i,
   input  logic [LANES*SMP_W-1:0]  smp_dat_i,
   input  logic [LANES-1:0]        rd_i,
   output logic [LANES*WORD_W-1:0] rd_data_o,
   output logic [LANES-1:0]        evt_o,
   output logic [LANES-1:0]        underrun_o,
   output logic [LANES-1:0]        overrun_o
);
   if (WORD_W % SMP_W != 0 || WORD_W / SMP_W < 2) begin : g_bad_pack
      $error("WORD_W must hold a whole number (at least 2) of samples");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two, at least 2");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("LANES must be at least 1");
   end

   logic [1:0] mode_q;
   logic       flush;

   assign flush = (mode_i != mode_q);

   always_ff @(posedge clk_i) begin
      if (!rst_n_i) mode_q <= CAP_COMPONENT;
      else          mode_q <= mode_i;
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic              act, vld, rd, wr;
      logic [WORD_W-1:0] word;
      logic [LVL_W-1:0]  lvl;

      assign act = lane_active(mode_q, l);
      assign vld = smp_vld_i[l] && act && !flush;
      assign rd  = rd_i[l] && act && !flush;

      capfifo_packer #(.SMP_W(SMP_W), .WORD_W(WORD_W)) u_pack (
         .clk_i(clk_i), .rst_n_i(rst_n_i), .flush_i(flush),
         .vld_i(vld), .dat_i(smp_dat_i[l*SMP_W +: SMP_W]),
         .wr_o(wr), .word_o(word)
      );

      capfifo_lane #(.WORD_W(WORD_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_fifo (
         .clk_i(clk_i), .rst_n_i(rst_n_i), .flush_i(flush),
         .wr_i(wr), .wr_word_i(word), .rd_i(rd), .thr_i(thresh_i),
         .rd_data_o(rd_data_o[l*WORD_W +: WORD_W]), .evt_o(evt_o[l]),
         .und_o(underrun_o[l]), .ovr_o(overrun_o[l]), .lvl_o(lvl)
      );

      if (l > 0) begin : g_chk_idle
         AST_IDLE_LANE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
            (mode_q != CAP_COMPONENT) |-> (lvl == '0 && !evt_o[l]
               && rd_data_o[l*WORD_W +: WORD_W] == '0)); // R8
      end
   end
endmodule

// File: tb/capture_fifo_bank_tb_top.sv
module capture_fifo_bank_tb_top;
   localparam int DEPTH = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   mode = 2'b00;
   logic [4:0]   thr = 5'd4;
   logic [2:0]   vld = '0;
   logic [23:0]  dat = '0;
   logic [2:0]   rd = '0;
   logic [191:0] rd_data;
   logic [2:0]   evt, und, ovr;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   capture_fifo_bank dut_i (
      .clk_i(clk), .rst_n_i(rst_n), .mode_i(mode), .thresh_i(thr),
      .smp_vld_i(vld), .smp_dat_i(dat), .rd_i(rd),
      .rd_data_o(rd_data), .evt_o(evt), .underrun_o(und), .overrun_o(ovr)
   );

   // Behavioural reference
   logic [63:0] mq [3][$];
   logic [63:0] m_part [3];
   logic [63:0] m_rd [3];
   int          m_cnt [3];
   logic [2:0]  m_evt, m_und, m_ovr, m_armed;
   logic [1:0]  m_mode;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int l = 0; l < 3; l++) begin
            mq[l].delete(); m_part[l] = '0; m_rd[l] = '0; m_cnt[l] = 0;
         end
         m_evt = '0; m_und = '0; m_ovr = '0; m_armed = '1; m_mode = 2'b00;
      end else if (mode != m_mode) begin
         for (int l = 0; l < 3; l++) begin
            mq[l].delete(); m_rd[l] = '0; m_cnt[l] = 0;
         end
         m_evt = '0; m_armed = '1; m_mode = mode;
      end else begin
         for (int l = 0; l < 3; l++) begin
            automatic bit act = (l == 0) || (m_mode == 2'b00);
            automatic int lv = mq[l].size();
            automatic int te = (thr == 0) ? 1 : int'(thr);
            automatic int nl;
            if (rd[l] && act) begin
               if (lv > 0) m_rd[l] = mq[l].pop_front();
               else begin m_rd[l] = '0; m_und[l] = 1'b1; end
            end
            if (vld[l] && act) begin
               m_part[l][m_cnt[l]*8 +: 8] = dat[l*8 +: 8];
               if (m_cnt[l] == 7) begin
                  if (lv < DEPTH) mq[l].push_back(m_part[l]);
                  else m_ovr[l] = 1'b1;
                  m_cnt[l] = 0;
               end else m_cnt[l]++;
            end
            nl = mq[l].size();
            if (m_armed[l] && nl >= te) begin
               m_evt[l] = 1'b1; m_armed[l] = 1'b0;
            end else begin
               m_evt[l] = 1'b0;
               if (nl < te) m_armed[l] = 1'b1;
            end
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Compare against the reference on every cycle, away from the rising edge
   always @(negedge clk) begin
      if (rst_n) begin
         for (int l = 0; l < 3; l++) begin
            chk(rd_data[l*64 +: 64] === m_rd[l], "R2 read data", rd_data[l*64 +: 64], m_rd[l]);
            chk(evt[l] === m_evt[l], "R5 event", 64'(evt[l]), 64'(m_evt[l]));
            chk(und[l] === m_und[l], "R6 underrun", 64'(und[l]), 64'(m_und[l]));
            chk(ovr[l] === m_ovr[l], "R7 overrun", 64'(ovr[l]), 64'(m_ovr[l]));
         end
      end
   end

   task automatic push(input int l, input logic [7:0] b);
      vld[l] = 1'b1; dat[l*8 +: 8] = b;
      @(negedge clk);
      vld[l] = 1'b0;
   endtask

   task automatic pop(input int l);
      rd[l] = 1'b1;
      @(negedge clk);
      rd[l] = 1'b0;
      @(negedge clk);
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(rd_data === '0 && evt === '0 && und === '0 && ovr === '0, "R1 reset state",
          {52'd0, evt, und, ovr, 3'd0}, 64'd0);

      // R3: little-endian packing order
      for (int i = 1; i <= 8; i++) push(0, 8'(i));
      pop(0);
      chk(rd_data[63:0] === 64'h0807060504030201, "R3 packing", rd_data[63:0], 64'h0807060504030201);

      // R6: empty read on lane 2
      pop(2);
      chk(und[2] === 1'b1 && rd_data[191:128] === '0, "R6 empty read", rd_data[191:128], 64'd0);

      // R4/R7: fill lane 0 past 16 words while reading at the full edge
      for (int w = 0; w < 16; w++)
         for (int i = 0; i < 8; i++) push(0, 8'(w * 8 + i));
      for (int i = 0; i < 7; i++) push(0, 8'hA0 + 8'(i));
      vld[0] = 1'b1; dat[7:0] = 8'hA7; rd[0] = 1'b1;
      @(negedge clk);
      vld[0] = 1'b0; rd[0] = 1'b0;
      chk(ovr[0] === 1'b1, "R7 overrun with same-edge read", 64'(ovr[0]), 64'd1);
      for (int w = 0; w < 15; w++) pop(0);
      chk(rd_data[63:0] === 64'h7f7e7d7c7b7a7978, "R4 sixteenth word kept",
          rd_data[63:0], 64'h7f7e7d7c7b7a7978);
      pop(0);
      chk(und[0] === 1'b1, "R7 dropped word not stored", 64'(und[0]), 64'd1);

      // R8: raw mode, chroma lane ignores samples and reads
      mode = 2'b01;
      @(negedge clk);
      for (int i = 0; i < 8; i++) push(1, 8'h55);
      pop(1);
      chk(rd_data[127:64] === '0 && und[1] === 1'b0 && evt[1] === 1'b0, "R8 idle chroma lane",
          rd_data[127:64], 64'd0);

      // R9/R10: partial word discarded by mode change, stream mode packs lane 0
      mode = 2'b00;
      @(negedge clk);
      for (int i = 0; i < 3; i++) push(0, 8'hEE);
      mode = 2'b10;
      @(negedge clk);
      for (int i = 0; i < 8; i++) push(0, 8'h10 + 8'(i));
      pop(0);
      chk(rd_data[63:0] === 64'h1716151413121110, "R9 R10 flush and stream packing",
          rd_data[63:0], 64'h1716151413121110);

      // Randomised traffic per mode and threshold
      for (int ph = 0; ph < 10; ph++) begin
         automatic int rdpct = (ph % 2 == 0) ? 3 : 20;
         mode = 2'((ph / 2) % 4);
         thr = (ph == 0) ? 5'd0 : (ph == 1) ? 5'd16 : 5'($urandom_range(0, 16));
         for (int c = 0; c < 2500; c++) begin
            for (int l = 0; l < 3; l++) begin
               vld[l] = ($urandom_range(0, 99) < 60);
               dat[l*8 +: 8] = 8'($urandom);
               rd[l] = ($urandom_range(0, 99) < rdpct);
            end
            @(negedge clk);
         end
         vld = '0; rd = '0;
      end
      @(negedge clk);
      summary();
      $finish;
   end
endmodule